// File: doc/BRIEF.md
# Pipelined Early-Out Multiply-Accumulate Unit

This unit is the multiply pipeline of an execution stage. It accepts signed 32-bit operations through a valid/ready issue port. Each operation carries an opcode, two operands, an accumulator value, a destination tag and three source tags. Word multiplies, halfword multiplies and the two accumulating forms all run on one shared 16x32 partial-product row.

When one operand's upper bits only repeat its sign, the product is built in a single pass of the row instead of two, so the result comes out one cycle sooner. Independent operations can enter while earlier ones are still in flight. An operation that reads an in-flight result as a multiplier operand is held at the port until that result reaches the result port.

An accumulate input that names the operation issued just before it is taken from an internal forwarding register, so it costs no issue cycles. Results leave in issue order, each with its destination tag.

Top module: `emac_top`

## Requirements
- R1: After reset, and after a reset applied while operations are in flight, `res_valid` is 0 and `iss_ready` is 1 while no source tag conflicts; an operation that was in flight at reset never produces a result.
- R2: Opcode 2'b00 (word multiply) returns the low 32 bits of the signed product of `iss_a` and `iss_b`.
- R3: Opcode 2'b01 (halfword multiply) returns the 32-bit signed product of the sign-extended bits 15:0 of both operands; bits 31:16 of the operands have no effect.
- R4: Opcode 2'b10 (word MAC) and 2'b11 (halfword MAC) return the accumulator plus the product of R2 or R3 respectively, as a 32-bit sum that wraps modulo 2^32.
- R5: An operand is narrow when bits 31 down to 15 are all equal. A word operation with at least one narrow operand, and every halfword operation, presents its result exactly 2 clock edges after the accepting edge. Any other operation takes exactly 3 edges.
- R6: Independent narrow operations are accepted on consecutive edges. While a non-narrow operation performs its first pass, `iss_ready` is 0, so the next operation is accepted 2 edges after it.
- R7: Each accepted operation produces exactly one result cycle, in issue order, with `res_dst` equal to its destination tag.
- R8: While an accepted operation whose result has not yet appeared on the result port has a destination tag equal to a nonzero `iss_src_a` or `iss_src_b`, `iss_ready` is 0. A dependent offered right behind a narrow producer is therefore accepted 3 edges after it.
- R9: A MAC whose nonzero `iss_src_acc` equals the destination of the immediately preceding accepted operation, still in flight, is not stalled for it. It ignores `iss_acc` and accumulates onto that operation's result.
- R10: A MAC whose nonzero `iss_src_acc` matches an in-flight operation other than the immediately preceding one is held as in R8, then uses `iss_acc`.
- R11: Source tag 0 means "no source": it never stalls and never forwards, even if an in-flight operation has destination 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request present |
| iss_ready | output | 1 | Unit accepts the request at this edge |
| iss_op | input | 2 | 00 word mul, 01 halfword mul, 10 word MAC, 11 halfword MAC |
| iss_a | input | 32 | First operand |
| iss_b | input | 32 | Second operand |
| iss_acc | input | 32 | Accumulator value for MAC opcodes |
| iss_dst | input | TAG_W | Destination tag |
| iss_src_a | input | TAG_W | Producer tag of `iss_a`, 0 for none |
| iss_src_b | input | TAG_W | Producer tag of `iss_b`, 0 for none |
| iss_src_acc | input | TAG_W | Producer tag of `iss_acc`, 0 for none |
| res_valid | output | 1 | Result present this cycle |
| res_dst | output | TAG_W | Destination tag of the result |
| res_data | output | 32 | Result value |

## Verification
The bench builds the unit with its default tag width of 4. This leaves fifteen usable tags, enough to keep several tagged operations in flight at once. It also lets tag 0 sit on a real in-flight destination, which is needed to show that a zero source never matches.

A table walked back to back covers the operand-size boundary (values one step either side of the 16-bit signed range), operand swapping, halfwords with noisy upper bits, and accumulator wrap. Directed sequences then place producers at each pipeline position to check stall spacing, forwarding, and reset during flight.

// File: rtl/emac_pkg.sv
package emac_pkg;

  localparam int DW = 32;
  localparam int HW = DW / 2;

  typedef enum logic [1:0] {
    OP_MULW = 2'b00,
    OP_MULH = 2'b01,
    OP_MACW = 2'b10,
    OP_MACH = 2'b11
  } emac_op_e;

  // Upper bits from HW-1 upward are pure sign copies.
  function automatic logic is_narrow(input logic [DW-1:0] x);
    return (&x[DW-1:HW-1]) | ~(|x[DW-1:HW-1]);
  endfunction

  function automatic logic [DW-1:0] half_sext(input logic [DW-1:0] x);
    return {{HW{x[HW-1]}}, x[HW-1:0]};
  endfunction

  // One row of the array: low DW bits of mcand times a HW-bit slice,
  // the slice read as signed when sgn is set.
  function automatic logic [DW-1:0] row_product(input logic [DW-1:0] mcand,
                                                input logic [HW-1:0] slice,
                                                input logic sgn);
    logic signed [HW:0]    s;
    logic signed [DW+HW:0] full;
    s    = {sgn & slice[HW-1], slice};
    full = $signed({{(HW+1){mcand[DW-1]}}, mcand}) * $signed({{DW{s[HW]}}, s});
    return full[DW-1:0];
  endfunction

endpackage

// File: rtl/emac_hazard.sv
module emac_hazard
  import emac_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0] src_a,
  input  logic [TAG_W-1:0] src_b,
  input  logic [TAG_W-1:0] src_acc,
  input  logic             is_mac,
  input  logic             s1_v,
  input  logic [TAG_W-1:0] s1_dst,
  input  logic             s2_v,
  input  logic [TAG_W-1:0] s2_dst,
  input  logic             s1_free,
  output logic             ready,
  output logic             opnd_haz,
  output logic             acc_fwd,
  output logic             acc_haz
);

  function automatic logic in_flight(input logic [TAG_W-1:0] t,
                                     input logic v1, input logic [TAG_W-1:0] d1,
                                     input logic v2, input logic [TAG_W-1:0] d2);
    return (t != '0) && ((v1 && d1 == t) || (v2 && d2 == t));
  endfunction

  logic             young_v;
  logic [TAG_W-1:0] young_dst;

  always_comb begin
    young_v   = s1_v | s2_v;
    young_dst = s1_v ? s1_dst : s2_dst;
    opnd_haz  = in_flight(src_a, s1_v, s1_dst, s2_v, s2_dst)
              | in_flight(src_b, s1_v, s1_dst, s2_v, s2_dst);
    acc_fwd   = is_mac && (src_acc != '0) && young_v && (young_dst == src_acc);
    acc_haz   = is_mac && in_flight(src_acc, s1_v, s1_dst, s2_v, s2_dst) && !acc_fwd;
    ready     = s1_free && !opnd_haz && !acc_haz;
  end

endmodule

// File: rtl/emac_mul_stage.sv
module emac_mul_stage
  import emac_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  emac_op_e         op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [DW-1:0]    acc_i,
  input  logic [TAG_W-1:0] dst_i,
  input  logic             fwd_i,
  output logic             v_o,
  output logic             last_o,
  output logic [TAG_W-1:0] dst_o,
  output logic [DW-1:0]    prod_o,
  output logic [DW-1:0]    acc_o,
  output logic             mac_o,
  output logic             fwd_o
);

  logic             v_q, hi_q, wide_q, mac_q, fwd_q;
  logic [DW-1:0]    mc_q, mr_q, acc_q, part_q;
  logic [TAG_W-1:0] dst_q;

  logic [DW-1:0] opa, opb, mc_d, mr_d, row, sum;
  logic          last;

  // Operand staging: halfword forms are sign-extended, and a narrow
  // operand is steered onto the slice side of the row.
  always_comb begin
    opa = op_i[0] ? half_sext(a_i) : a_i;
    opb = op_i[0] ? half_sext(b_i) : b_i;
    if (is_narrow(opb)) begin
      mc_d = opa;
      mr_d = opb;
    end else if (is_narrow(opa)) begin
      mc_d = opb;
      mr_d = opa;
    end else begin
      mc_d = opa;
      mr_d = opb;
    end
  end

  // Row pass: low slice (unsigned on a two-pass product), then high slice.
  always_comb begin
    if (hi_q) begin
      row = row_product(mc_q, mr_q[DW-1:HW], 1'b1);
      sum = part_q + {row[HW-1:0], {HW{1'b0}}};
    end else begin
      row = row_product(mc_q, mr_q[HW-1:0], ~wide_q);
      sum = row;
    end
    last = v_q && (!wide_q || hi_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      hi_q   <= 1'b0;
      wide_q <= 1'b0;
      mac_q  <= 1'b0;
      fwd_q  <= 1'b0;
      mc_q   <= '0;
      mr_q   <= '0;
      acc_q  <= '0;
      part_q <= '0;
      dst_q  <= '0;
    end else if (load_i) begin
      v_q    <= 1'b1;
      hi_q   <= 1'b0;
      wide_q <= !is_narrow(mr_d);
      mac_q  <= op_i[1];
      fwd_q  <= fwd_i;
      mc_q   <= mc_d;
      mr_q   <= mr_d;
      acc_q  <= acc_i;
      dst_q  <= dst_i;
    end else if (v_q && !last) begin
      hi_q   <= 1'b1;
      part_q <= row;
    end else if (last) begin
      v_q  <= 1'b0;
      hi_q <= 1'b0;
    end
  end

  assign v_o    = v_q;
  assign last_o = last;
  assign dst_o  = dst_q;
  assign prod_o = sum;
  assign acc_o  = acc_q;
  assign mac_o  = mac_q;
  assign fwd_o  = fwd_q;

endmodule

// File: rtl/emac_acc_stage.sv
module emac_acc_stage
  import emac_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [DW-1:0]    in_prod,
  input  logic [DW-1:0]    in_acc,
  input  logic [TAG_W-1:0] in_dst,
  input  logic             in_mac,
  input  logic             in_fwd,
  output logic             s2_v_o,
  output logic [TAG_W-1:0] s2_dst_o,
  output logic             res_valid,
  output logic [TAG_W-1:0] res_dst,
  output logic [DW-1:0]    res_data
);

  logic             v_q, mac_q, fwd_q;
  logic [DW-1:0]    prod_q, acc_q, last_q;
  logic [TAG_W-1:0] dst_q;
  logic [DW-1:0]    addend, total;

  // last_q always holds the most recently retired result, which is the
  // adjacent predecessor's value whenever fwd_q is set.
  always_comb begin
    addend = !mac_q ? '0 : (fwd_q ? last_q : acc_q);
    total  = prod_q + addend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q       <= 1'b0;
      mac_q     <= 1'b0;
      fwd_q     <= 1'b0;
      prod_q    <= '0;
      acc_q     <= '0;
      dst_q     <= '0;
      last_q    <= '0;
      res_valid <= 1'b0;
      res_dst   <= '0;
      res_data  <= '0;
    end else begin
      v_q       <= in_v;
      mac_q     <= in_mac;
      fwd_q     <= in_fwd;
      prod_q    <= in_prod;
      acc_q     <= in_acc;
      dst_q     <= in_dst;
      res_valid <= v_q;
      if (v_q) begin
        res_dst  <= dst_q;
        res_data <= total;
        last_q   <= total;
      end
    end
  end

  assign s2_v_o   = v_q;
  assign s2_dst_o = dst_q;

endmodule

// File: rtl/emac_top.sv
module emac_top
  import emac_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [1:0]       iss_op,
  input  logic [DW-1:0]    iss_a,
  input  logic [DW-1:0]    iss_b,
  input  logic [DW-1:0]    iss_acc,
  input  logic [TAG_W-1:0] iss_dst,
  input  logic [TAG_W-1:0] iss_src_a,
  input  logic [TAG_W-1:0] iss_src_b,
  input  logic [TAG_W-1:0] iss_src_acc,
  output logic             res_valid,
  output logic [TAG_W-1:0] res_dst,
  output logic [DW-1:0]    res_data
);

  // Named internal events, observed by the bound checker.
  logic             s1_v, s1_last, s1_free, s1_mac, s1_fwd;
  logic [TAG_W-1:0] s1_dst, s2_dst;
  logic             s2_v;
  logic [DW-1:0]    s1_prod, s1_acc;
  logic             accept, opnd_haz, acc_fwd, acc_haz;

  assign s1_free = !s1_v || s1_last;
  assign accept  = iss_valid && iss_ready;

  emac_hazard #(.TAG_W(TAG_W)) u_hazard (
    .src_a    (iss_src_a),
    .src_b    (iss_src_b),
    .src_acc  (iss_src_acc),
    .is_mac   (iss_op[1]),
    .s1_v     (s1_v),
    .s1_dst   (s1_dst),
    .s2_v     (s2_v),
    .s2_dst   (s2_dst),
    .s1_free  (s1_free),
    .ready    (iss_ready),
    .opnd_haz (opnd_haz),
    .acc_fwd  (acc_fwd),
    .acc_haz  (acc_haz)
  );

  emac_mul_stage #(.TAG_W(TAG_W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .op_i   (emac_op_e'(iss_op)),
    .a_i    (iss_a),
    .b_i    (iss_b),
    .acc_i  (iss_acc),
    .dst_i  (iss_dst),
    .fwd_i  (acc_fwd),
    .v_o    (s1_v),
    .last_o (s1_last),
    .dst_o  (s1_dst),
    .prod_o (s1_prod),
    .acc_o  (s1_acc),
    .mac_o  (s1_mac),
    .fwd_o  (s1_fwd)
  );

  emac_acc_stage #(.TAG_W(TAG_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_v      (s1_last),
    .in_prod   (s1_prod),
    .in_acc    (s1_acc),
    .in_dst    (s1_dst),
    .in_mac    (s1_mac),
    .in_fwd    (s1_fwd),
    .s2_v_o    (s2_v),
    .s2_dst_o  (s2_dst),
    .res_valid (res_valid),
    .res_dst   (res_dst),
    .res_data  (res_data)
  );

endmodule

// File: rtl/emac_chk.sv
module emac_chk
  import emac_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [1:0]       iss_op,
  input logic [DW-1:0]    iss_a,
  input logic [DW-1:0]    iss_b,
  input logic [TAG_W-1:0] iss_src_a,
  input logic [TAG_W-1:0] iss_src_b,
  input logic [TAG_W-1:0] iss_src_acc,
  input logic             s1_v,
  input logic             s1_last,
  input logic [TAG_W-1:0] s1_dst,
  input logic             s2_v,
  input logic [TAG_W-1:0] s2_dst,
  input logic             res_valid,
  input logic [TAG_W-1:0] res_dst
);

  localparam int LIM = 2 ** (HW - 1);

  logic fits_a, fits_b, short_op, take;
  assign fits_a   = ($signed(iss_a) >= -LIM) && ($signed(iss_a) < LIM);
  assign fits_b   = ($signed(iss_b) >= -LIM) && ($signed(iss_b) < LIM);
  assign short_op = iss_op[0] || fits_a || fits_b;
  assign take     = iss_valid && iss_ready;

  AST_SHORT_ONE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    take && short_op |=> s1_v && s1_last); // R5
  AST_LONG_TWO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    take && !short_op |=> s1_v && !s1_last); // R5
  AST_SECOND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && !s1_last |=> s1_v && s1_last); // R6
  AST_FIRST_PASS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && !s1_last |-> !iss_ready); // R6
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v |=> res_valid && res_dst == $past(s2_dst)); // R7
  AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_v |=> !res_valid); // R7
  AST_OPERAND_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_src_a != '0 && s2_v && s2_dst == iss_src_a |-> !iss_ready); // R8
  AST_FWD_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_op[1] && iss_src_acc != '0 && s1_v && s1_last &&
    s1_dst == iss_src_acc && iss_src_a == '0 && iss_src_b == '0 |-> iss_ready); // R9

endmodule

bind emac_top emac_chk #(.TAG_W(TAG_W)) u_emac_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .iss_valid   (iss_valid),
  .iss_ready   (iss_ready),
  .iss_op      (iss_op),
  .iss_a       (iss_a),
  .iss_b       (iss_b),
  .iss_src_a   (iss_src_a),
  .iss_src_b   (iss_src_b),
  .iss_src_acc (iss_src_acc),
  .s1_v        (s1_v),
  .s1_last     (s1_last),
  .s1_dst      (s1_dst),
  .s2_v        (s2_v),
  .s2_dst      (s2_dst),
  .res_valid   (res_valid),
  .res_dst     (res_dst)
);

// File: tb/test_emac_top.sv
module test_emac_top;

  localparam int TAG_W = 4;
  localparam int NV    = 14;
  // {op, a, b, acc}
  localparam logic [97:0] VEC [NV] = '{
    {2'b00, 32'h0000_0007, 32'h0000_0006, 32'h0},
    {2'b00, 32'hFFFF_8000, 32'h0000_7FFF, 32'h0},
    {2'b00, 32'h0000_0003, 32'h0000_8000, 32'h0},
    {2'b00, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0},
    {2'b00, 32'hFFFF_7FFF, 32'h0001_0001, 32'h0},
    {2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0},
    {2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0},
    {2'b01, 32'hABCD_8001, 32'h1234_FFFF, 32'h0},
    {2'b01, 32'h0000_7FFF, 32'h0000_8000, 32'h0},
    {2'b10, 32'h0001_0000, 32'h0001_0000, 32'h0000_0001},
    {2'b10, 32'h0000_0002, 32'h4000_0000, 32'h7FFF_FFFF},
    {2'b11, 32'hFFFF_8000, 32'h0000_8000, 32'h8000_0000},
    {2'b10, 32'h8765_4321, 32'h0FED_CBA9, 32'hDEAD_BEEF},
    {2'b11, 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             iss_valid, iss_ready;
  logic [1:0]       iss_op;
  logic [31:0]      iss_a, iss_b, iss_acc, res_data;
  logic [TAG_W-1:0] iss_dst, iss_src_a, iss_src_b, iss_src_acc, res_dst;
  logic             res_valid;

  always #2 clk = ~clk;

  emac_top #(.TAG_W(TAG_W)) i_emac_top (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b), .iss_acc(iss_acc),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_src_acc(iss_src_acc), .res_valid(res_valid), .res_dst(res_dst),
    .res_data(res_data)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, nacc = 0, ridx = 0, rtot = 0;
  logic [31:0] e_data [64];
  logic [31:0] e_dst  [64];
  int          e_lat  [64];
  int          a_edge [64];
  string       e_req  [64];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] acc);
    longint p;
    shortint ha, hb;
    int sa, sb;
    sa = a; sb = b; ha = a[15:0]; hb = b[15:0];
    p = op[0] ? longint'(ha) * longint'(hb) : longint'(sa) * longint'(sb);
    return p[31:0] + (op[1] ? acc : 32'h0);
  endfunction

  function automatic bit fits(input logic [31:0] x);
    int s;
    s = x;
    return (s >= -32768) && (s <= 32767);
  endfunction

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] acc, input logic [3:0] dst, input logic [3:0] sa,
                       input logic [3:0] sb, input logic [3:0] sc, input logic [31:0] acc_used);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = op; iss_a = a; iss_b = b; iss_acc = acc;
    iss_dst = dst; iss_src_a = sa; iss_src_b = sb; iss_src_acc = sc;
    #1;
    while (!iss_ready) begin
      @(negedge clk);
      #1;
    end
    e_data[nacc] = model(op, a, b, acc_used);
    e_dst[nacc]  = 32'(dst);
    e_lat[nacc]  = (op[0] || fits(a) || fits(b)) ? 2 : 3;
    e_req[nacc]  = op[1] ? "R4" : (op[0] ? "R3" : "R2");
    a_edge[nacc] = cyc + 1;
    nacc++;
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  task automatic drain();
    for (int t = 0; t < 50 && ridx < nacc; t++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      rtot++;
      if (ridx >= nacc) begin
        n_chk++; n_bad++;
        $display("FAIL R7: actual unexpected result tag %0d expected none", res_dst);
      end else begin
        check(e_req[ridx], res_data, e_data[ridx]);
        check("R7", 32'(res_dst), e_dst[ridx]);
        check("R5", 32'(cyc - a_edge[ridx]), 32'(e_lat[ridx]));
        ridx++;
      end
    end
  end

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int k, snap;
    rst_n = 1'b0; iss_valid = 1'b0; iss_op = '0; iss_a = '0; iss_b = '0; iss_acc = '0;
    iss_dst = '0; iss_src_a = '0; iss_src_b = '0; iss_src_acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(res_valid), 32'd0);
    check("R1", 32'(iss_ready), 32'd1);

    // Table walk, back to back, independent tags (R2 R3 R4 R5 R7).
    for (int i = 0; i < NV; i++)
      issue(VEC[i][97:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0],
            4'(i % 15 + 1), 4'd0, 4'd0, 4'd0, VEC[i][31:0]);
    drain();

    // R6: narrow ops on consecutive edges, wide op costs an extra edge.
    k = nacc;
    for (int i = 0; i < 4; i++) issue(2'b00, 32'(i + 2), 32'h11, 0, 4'(i + 1), 0, 0, 0, 0);
    for (int i = 1; i < 4; i++) check("R6", 32'(a_edge[k+i] - a_edge[k+i-1]), 32'd1);
    issue(2'b00, 32'h0012_3456, 32'h0765_4321, 0, 4'd5, 0, 0, 0, 0);
    issue(2'b00, 32'h5, 32'h9, 0, 4'd6, 0, 0, 0, 0);
    check("R6", 32'(a_edge[nacc-1] - a_edge[nacc-2]), 32'd2);
    drain();

    // R8: operand dependency via a and via b.
    issue(2'b00, 32'h3, 32'h4, 0, 4'd5, 0, 0, 0, 0);
    issue(2'b00, 32'hC, 32'h2, 0, 4'd6, 4'd5, 0, 0, 0);
    check("R8", 32'(a_edge[nacc-1] - a_edge[nacc-2]), 32'd3);
    issue(2'b01, 32'h7, 32'h8, 0, 4'd10, 0, 0, 0, 0);
    issue(2'b00, 32'h2, 32'h38, 0, 4'd11, 0, 4'd10, 0, 0);
    check("R8", 32'(a_edge[nacc-1] - a_edge[nacc-2]), 32'd3);
    drain();

    // R9: accumulate forwarding chain, port value is garbage.
    issue(2'b10, 32'h10, 32'h10, 32'd100, 4'd6, 0, 0, 0, 32'd100);
    issue(2'b10, 32'h3, 32'h5, 32'hDEAD_BEEF, 4'd7, 0, 0, 4'd6, e_data[nacc-1]);
    check("R9", 32'(a_edge[nacc-1] - a_edge[nacc-2]), 32'd1);
    issue(2'b11, 32'hFFFF_FFFE, 32'h0000_0009, 32'h1234_5678, 4'd8, 0, 0, 4'd7, e_data[nacc-1]);
    check("R9", 32'(a_edge[nacc-1] - a_edge[nacc-2]), 32'd1);
    issue(2'b10, 32'h0123_4567, 32'h0765_4321, 32'd5, 4'd9, 0, 0, 0, 32'd5);
    issue(2'b10, 32'h0, 32'h7, 32'hFFFF_0000, 4'd10, 0, 0, 4'd9, e_data[nacc-1]);
    check("R9", 32'(a_edge[nacc-1] - a_edge[nacc-2]), 32'd2);
    drain();

    // R10: accumulate source is an older in-flight op.
    issue(2'b00, 32'h6, 32'h7, 0, 4'd8, 0, 0, 0, 0);
    issue(2'b00, 32'h2, 32'h2, 0, 4'd9, 0, 0, 0, 0);
    issue(2'b10, 32'h4, 32'h4, e_data[nacc-2], 4'd12, 0, 0, 4'd8, e_data[nacc-2]);
    check("R10", 32'(a_edge[nacc-1] - a_edge[nacc-2]), 32'd2);
    drain();

    // R11: tag 0 is never a source, even with dst 0 in flight.
    issue(2'b00, 32'h9, 32'h9, 0, 4'd0, 0, 0, 0, 0);
    issue(2'b10, 32'h1, 32'h1, 32'd1234, 4'd3, 4'd0, 4'd0, 4'd0, 32'd1234);
    check("R11", 32'(a_edge[nacc-1] - a_edge[nacc-2]), 32'd1);
    drain();

    // R1: reset with an op in flight discards it.
    issue(2'b00, 32'h0123_4567, 32'h0765_4321, 0, 4'd3, 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    ridx = nacc;
    snap = rtot;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", 32'(rtot - snap), 32'd0);
    check("R1", 32'(res_valid), 32'd0);
    check("R1", 32'(iss_ready), 32'd1);

    summary();
    $finish;
  end

endmodule